// File: doc/BRIEF.md
# Status Register Write-Protect Lock

This block holds two bits of a serial memory's status register. The protect bit guards the memory array. The lock bit decides whether the protect bit may still be changed. A status-register write arrives as a one-cycle strobe that carries new values for both bits. The block accepts the write, or refuses all of it, depending on the lock bit and on the level of the active-low write-protect pin.

The register is hardware locked only when the pin is driven low and the lock bit is 1. While it is locked, a write changes neither bit. In that state the register can be released in two ways: raise the pin, or apply a power-on reset. Setting the lock bit while the pin is high does not freeze the protect bit. Command decoding and the enforcement of protection on array operations happen outside this block.

Top module: `sr_wp_lock`

## Requirements
- R1: After power-on reset (por_n_i low), prot_o and lock_o are 0. With lock_o at 0, hwlock_o is 0.
- R2: With wp_n_i low and lock_o at 0, a strobe copies st_prot_i into prot_o and st_lock_i into lock_o. A 0 written to a lock that is already 0 keeps it at 0. The new values appear after the next rising clock edge.
- R3: With wp_n_i low and lock_o at 1, a strobe changes neither prot_o nor lock_o.
- R4: With wp_n_i high and lock_o at 0, a strobe writes prot_o and may set lock_o to 1.
- R5: With wp_n_i high and lock_o at 1, a strobe writes prot_o and clears lock_o to 0 when st_lock_i is 0.
- R6: hwlock_o is 1 exactly when wp_n_i is low and lock_o is 1. It follows the pin in the same cycle.
- R7: Without a strobe (st_wr_i low), prot_o and lock_o hold their values.
- R8: The lock condition is taken from the level of wp_n_i in the cycle of the strobe. While wp_n_i stays low, a lock_o of 1 is cleared only by power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| wp_n_i | input | 1 | Write-protect pin, active low |
| st_wr_i | input | 1 | Status-register write strobe, one cycle |
| st_prot_i | input | 1 | New value for the protect bit |
| st_lock_i | input | 1 | New value for the lock bit |
| prot_o | output | 1 | Current protect bit |
| lock_o | output | 1 | Current lock bit |
| hwlock_o | output | 1 | Register is hardware locked |

## Verification
The assertions check the following on every cycle:
- The bits hold when there is no strobe.
- A locked register ignores strobes.
- A set request always leaves the lock bit at 1.
- An unlocked strobe writes the protect bit.
- A clear request with the pin high always succeeds.
- The locked flag persists while the pin stays low.

The bench scenarios cover the remaining cases: every combination of pin level and lock state in sequence, a pin released in the very cycle of the strobe, and the release of a pin-held lock by power-on reset.

// File: rtl/sr_wp_lock.sv
module sr_wp_lock (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic wp_n_i,
  input  logic st_wr_i,
  input  logic st_prot_i,
  input  logic st_lock_i,
  output logic prot_o,
  output logic lock_o,
  output logic hwlock_o
);

  logic frozen;
  logic accept;

  assign frozen   = ~wp_n_i & lock_o;
  assign accept   = st_wr_i & ~frozen;
  assign hwlock_o = frozen;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      prot_o <= 1'b0;
      lock_o <= 1'b0;
    end else if (accept) begin
      prot_o <= st_prot_i;
      lock_o <= st_lock_i;
    end
  end

endmodule

module sr_wp_lock_chk (
  input logic clk_i,
  input logic por_n_i,
  input logic wp_n_i,
  input logic st_wr_i,
  input logic st_prot_i,
  input logic st_lock_i,
  input logic prot_o,
  input logic lock_o,
  input logic hwlock_o
);

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !st_wr_i |=> ($stable(prot_o) && $stable(lock_o))); // R7

  AST_FROZEN_WRITE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (st_wr_i && !wp_n_i && lock_o) |=> ($stable(prot_o) && $stable(lock_o))); // R3

  AST_LOCK_SET: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (st_wr_i && st_lock_i) |=> lock_o); // R4

  AST_PROT_WRITE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (st_wr_i && (wp_n_i || !lock_o)) |=> (prot_o == $past(st_prot_i))); // R2

  AST_LOCK_CLEAR: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (st_wr_i && wp_n_i && !st_lock_i) |=> !lock_o); // R5

  AST_LOCK_PERSIST: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (hwlock_o && !wp_n_i) |=> (lock_o || wp_n_i)); // R8

endmodule

bind sr_wp_lock sr_wp_lock_chk i_sr_wp_lock_chk (.*);

// File: tb/test_sr_wp_lock.sv
module test_sr_wp_lock;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // {wp_n, wr, prot_in, lock_in, exp_prot, exp_lock, exp_hw}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_1_1_0_1_0_0, // R2 write prot, pin low, unlocked
    7'b0_1_0_0_0_0_0, // R2 clear prot, lock stays 0
    7'b0_1_1_1_1_1_1, // R2 set lock with pin low -> hw locked (R6)
    7'b0_1_0_0_1_1_1, // R3 write ignored while locked
    7'b0_0_0_0_1_1_1, // R7 idle hold
    7'b1_0_0_0_1_1_0, // R6 flag drops with pin high
    7'b1_1_0_1_0_1_0, // R5 prot writable with lock set, pin high
    7'b1_1_1_0_1_0_0, // R5 lock cleared with pin high
    7'b1_1_0_1_0_1_0, // R4 lock set with pin high
    7'b0_0_0_0_0_1_1, // R8 pin asserted -> locked
    7'b0_1_1_0_0_1_1, // R3 locked write ignored
    7'b1_1_0_0_0_0_0, // R8 pin released in strobe cycle -> clear allowed
    7'b1_1_1_0_1_0_0  // R4 prot writable, lock stays 0
  };

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic wp_n = 1'b1;
  logic st_wr = 1'b0;
  logic st_prot = 1'b0;
  logic st_lock = 1'b0;
  logic prot, lock, hwlock;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_wp_lock i_sr_wp_lock (
    .clk_i(clk), .por_n_i(por_n), .wp_n_i(wp_n), .st_wr_i(st_wr),
    .st_prot_i(st_prot), .st_lock_i(st_lock),
    .prot_o(prot), .lock_o(lock), .hwlock_o(hwlock)
  );

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({prot, lock, hwlock} !== exp) begin
      errors++;
      $display("FAIL %s: {prot,lock,hw} actual=%b expected=%b", req, {prot, lock, hwlock}, exp);
    end
  endtask

  task automatic apply(input logic w, input logic e, input logic p, input logic l);
    @(negedge clk);
    wp_n = w; st_wr = e; st_prot = p; st_lock = l;
    @(posedge clk);
    #1;
    st_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 3'b000);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 3'b000);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      wp_n = VEC[i][6];
      #1;
      check($sformatf("vector %0d", i), VEC[i][2:0]);
    end

    // R8: lock under held-low pin, repeated clear attempts fail, reset clears
    apply(1'b0, 1'b1, 1'b1, 1'b1);
    check("R8 lock set", 3'b111);
    for (int k = 0; k < 3; k++) begin
      apply(1'b0, 1'b1, 1'b0, 1'b0);
      check("R8 clear attempt with pin low", 3'b111);
    end
    @(negedge clk);
    por_n = 1'b0;
    #1;
    check("R1 R8 power-on reset clears lock", 3'b000);
    @(negedge clk);
    por_n = 1'b1;
    apply(1'b0, 1'b1, 1'b1, 1'b0);
    check("R2 writable after reset", 3'b100);
    // R6 flag follows pin combinationally
    apply(1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    wp_n = 1'b1;
    #1;
    check("R6 pin high same cycle", 3'b110);
    wp_n = 1'b0;
    #1;
    check("R6 pin low same cycle", 3'b111);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule